// File: doc/BRIEF.md
# Two-wire serial memory slave

This block is the bus-facing half of a 4K x 8 serial memory. It samples the two-wire bus clock and data lines in the system clock domain and detects the start and stop conditions. It shifts bytes in most significant bit first and checks the first byte after a start against a fixed device-type prefix and three strap inputs. It then acknowledges by pulling its open-drain data output low. A write selects a 12-bit word address carried in two bytes and stores any data bytes that follow. A read returns bytes from an internal pointer, which a master either uses as it is (current-address read) or sets first with an address-only write followed by a repeated start (random read).

The storage is a plain synchronous RAM inside the block. An external self-timed write engine reports through `busy_i`. While that input is high the slave acknowledges nothing, so a master can poll for completion by sending a control byte until it sees an acknowledge. Every change of the data output is delayed by a fixed number of system clocks after the synchronized clock falls, which keeps hold time on the bus.

Top module: `i2cm_slave`

## Requirements
- R1: After reset `sda_oe` is 0. A start (data falling while clock is high) seen in any state, including in the middle of a byte, restarts control-byte reception. A stop (data rising while clock is high) returns the block to idle with `sda_oe` at 0.
- R2: A control byte whose bits [7:4] are 1010 and bits [3:1] equal `strap_i`, with bit 0 as read (1) or write (0), is acknowledged: `sda_oe` is 1 for the whole high phase of the ninth clock.
- R3: A control byte with a wrong prefix or wrong strap bits gets no acknowledge. Every byte that follows, up to the next start, gets no acknowledge and does not change the memory.
- R4: After a write control byte, the high and then the low address byte are acknowledged. The word address is the low 12 bits of {high, low}, so the top four bits of the high byte have no effect.
- R5: While `busy_i` is 1 at the end of a byte, that byte gets no acknowledge, including the control byte, and no memory write happens.
- R6: Each data byte after the two address bytes of a write is acknowledged and stored at the pointer, and the pointer then advances by one. Further bytes go to successive addresses.
- R7: A read control byte sent directly after a start returns the byte at the address after the last one written or read.
- R8: A write control byte with two address bytes and no data, followed by a repeated start and a read control byte, returns the byte at that address.
- R9: In a read, a master acknowledge (data low on the ninth clock) makes the next byte follow at the next address. A master no-acknowledge leaves `sda_oe` at 0 until the next start.
- R10: The pointer wraps from 0xFFF to 0x000, both when writing and when reading.
- R11: `sda_oe` changes only while the bus clock is low, `HOLD_CYC` system clocks after its synchronized falling edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than the bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad (wired-AND of all drivers) |
| sda_oe | output | 1 | 1 pulls the data line low, 0 releases it |
| strap_i | input | 3 | Device select straps compared with control byte bits [3:1] |
| busy_i | input | 1 | Self-timed write in progress; suppresses every acknowledge |

## Verification
The bus lines pass through a two-stage synchronizer and an edge register. The command register and a `HOLD_CYC` countdown follow, so an acknowledge or read bit appears about seven system clocks after the bus clock falls. The master in the bench samples the line in the middle of the following high phase, well after that point, and compares it with a behavioural model built on a byte array and an integer pointer. A separate monitor runs on every clock and flags any change of `sda_oe` while the bus clock is high. Memory effects, and the absence of memory effects, are checked later through reads over the bus.

// File: rtl/i2cm_pkg.sv
// Shared types and constants for the two-wire memory slave.
// Assumes an 8-bit byte and a 4-bit device-type prefix in the control byte.
package i2cm_pkg;
    localparam int          BYTE_W      = 8;
    localparam int          CNT_W       = 4;
    localparam int          STRAP_W     = 3;
    localparam logic [3:0]  CTRL_PREFIX = 4'b1010;

    // Transfer phase of the slave
    typedef enum logic [2:0] {
        PH_IDLE,
        PH_CTRL,
        PH_AHI,
        PH_ALO,
        PH_WDAT,
        PH_RDAT,
        PH_SKIP
    } phase_t;
endpackage

// File: rtl/i2cm_line_sync.sv
// Synchronizes the bus clock and data lines into the system clock domain.
// It flags clock edges and start/stop conditions, one cycle wide each.
// Assumes both lines idle high and stay stable for several system clocks.
module i2cm_line_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_lvl,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    localparam int LAST = SYNC_STAGES - 1;

    logic [LAST:0] scl_pipe;
    logic [LAST:0] sda_pipe;
    logic          scl_d;
    logic          sda_d;
    logic          scl_lvl;

    // Synchronizer chains plus one delayed copy of each line for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_pipe <= '1;
            sda_pipe <= '1;
            scl_d    <= 1'b1;
            sda_d    <= 1'b1;
        end else begin
            scl_pipe <= {scl_pipe[LAST-1:0], scl_i};
            sda_pipe <= {sda_pipe[LAST-1:0], sda_i};
            scl_d    <= scl_pipe[LAST];
            sda_d    <= sda_pipe[LAST];
        end
    end

    // Edge and bus-condition decode
    always_comb begin
        scl_lvl   = scl_pipe[LAST];
        sda_lvl   = sda_pipe[LAST];
        scl_rise  = scl_lvl && !scl_d;
        scl_fall  = !scl_lvl && scl_d;
        start_det = scl_lvl && scl_d && sda_d && !sda_lvl;
        stop_det  = scl_lvl && scl_d && !sda_d && sda_lvl;
    end
endmodule

// File: rtl/i2cm_sda_drv.sv
// Open-drain data output stage. A request loads a value that is applied
// HOLD_CYC system clocks later, which keeps data hold time after a clock fall.
// Assumes requests come at least HOLD_CYC clocks apart.
module i2cm_sda_drv #(
    parameter int HOLD_CYC = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic drv_req,
    input  logic drv_val,
    output logic sda_oe
);
    localparam int CW = $clog2(HOLD_CYC + 1);

    logic [CW-1:0] cnt;
    logic          pend;

    // Countdown from request to application of the new output value
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt    <= '0;
            pend   <= 1'b0;
            sda_oe <= 1'b0;
        end else if (drv_req) begin
            cnt    <= CW'(HOLD_CYC);
            pend   <= drv_val;
        end else if (cnt != '0) begin
            cnt    <= cnt - 1'b1;
            if (cnt == CW'(1)) begin
                sda_oe <= pend;
            end
        end
    end
endmodule

// File: rtl/i2cm_ram.sv
// Plain synchronous single-port-write, registered-read byte memory.
// Read data reflects the read address of the previous cycle; no reset.
module i2cm_ram #(
    parameter int AW = 12,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];

    // Write port and registered read port
    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
        rdata <= mem[raddr];
    end
endmodule

// File: rtl/i2cm_proto.sv
// Byte-level protocol engine: counts bits, decodes control and address bytes,
// issues acknowledge and read-bit drive requests and memory writes, and keeps
// the address pointer. Assumes one-cycle edge and condition pulses from the
// synchronizer and registered read data that follows ptr by one cycle.
module i2cm_proto
    import i2cm_pkg::*;
#(
    parameter int AW = 12
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               scl_rise,
    input  logic               scl_fall,
    input  logic               start_det,
    input  logic               stop_det,
    input  logic               sda_lvl,
    input  logic [STRAP_W-1:0] strap_i,
    input  logic               busy_i,
    input  logic [BYTE_W-1:0]  rd_data,
    output phase_t             phase,
    output logic               byte_evt,
    output logic               drv_req,
    output logic               drv_val,
    output logic               ram_we,
    output logic [AW-1:0]      ram_waddr,
    output logic [BYTE_W-1:0]  ram_wdata,
    output logic [AW-1:0]      ptr
);
    localparam logic [CNT_W-1:0] ACK_SLOT = CNT_W'(BYTE_W);
    localparam logic [CNT_W-1:0] END_SLOT = CNT_W'(BYTE_W + 1);

    logic [CNT_W-1:0]  bitcnt;
    logic [BYTE_W-1:0] shreg;
    logic [BYTE_W-1:0] tx;
    logic [BYTE_W-1:0] addr_hi;
    logic              rd_sel;
    logic              m_ack;
    logic              active;
    logic              ctrl_hit;
    logic [2:0]        tx_idx;

    // Decode of the current state and the received byte
    always_comb begin
        active   = (phase != PH_IDLE) && (phase != PH_SKIP);
        ctrl_hit = (shreg[7:4] == CTRL_PREFIX) && (shreg[3:1] == strap_i);
        byte_evt = active && scl_fall && (bitcnt == ACK_SLOT);
        tx_idx   = 3'(4'd7 - bitcnt);
    end

    // Transfer sequencing, pointer and drive requests
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase     <= PH_IDLE;
            bitcnt    <= '0;
            shreg     <= '0;
            tx        <= '0;
            addr_hi   <= '0;
            rd_sel    <= 1'b0;
            m_ack     <= 1'b0;
            drv_req   <= 1'b0;
            drv_val   <= 1'b0;
            ram_we    <= 1'b0;
            ram_waddr <= '0;
            ram_wdata <= '0;
            ptr       <= '0;
        end else begin
            drv_req <= 1'b0;
            ram_we  <= 1'b0;
            if (start_det) begin
                phase  <= PH_CTRL;
                bitcnt <= '0;
            end else if (stop_det) begin
                phase  <= PH_IDLE;
                bitcnt <= '0;
            end else if (active && scl_rise) begin
                if (bitcnt < ACK_SLOT) begin
                    shreg  <= {shreg[BYTE_W-2:0], sda_lvl};
                    bitcnt <= bitcnt + 1'b1;
                end else if (bitcnt == ACK_SLOT) begin
                    bitcnt <= END_SLOT;
                    if (phase == PH_RDAT) begin
                        m_ack <= !sda_lvl;
                        ptr   <= ptr + 1'b1;
                    end
                end
            end else if (active && scl_fall) begin
                if (bitcnt == ACK_SLOT) begin
                    unique case (phase)
                        PH_RDAT: begin
                            drv_req <= 1'b1;
                            drv_val <= 1'b0;
                        end
                        PH_CTRL: begin
                            if (ctrl_hit && !busy_i) begin
                                drv_req <= 1'b1;
                                drv_val <= 1'b1;
                                rd_sel  <= shreg[0];
                            end else begin
                                phase <= PH_SKIP;
                            end
                        end
                        PH_AHI: begin
                            if (!busy_i) begin
                                drv_req <= 1'b1;
                                drv_val <= 1'b1;
                                addr_hi <= shreg;
                            end else begin
                                phase <= PH_SKIP;
                            end
                        end
                        PH_ALO: begin
                            if (!busy_i) begin
                                drv_req <= 1'b1;
                                drv_val <= 1'b1;
                                ptr     <= AW'({addr_hi, shreg});
                            end else begin
                                phase <= PH_SKIP;
                            end
                        end
                        PH_WDAT: begin
                            if (!busy_i) begin
                                drv_req   <= 1'b1;
                                drv_val   <= 1'b1;
                                ram_we    <= 1'b1;
                                ram_waddr <= ptr;
                                ram_wdata <= shreg;
                                ptr       <= ptr + 1'b1;
                            end else begin
                                phase <= PH_SKIP;
                            end
                        end
                        default: ;
                    endcase
                end else if (bitcnt == END_SLOT) begin
                    bitcnt  <= '0;
                    drv_req <= 1'b1;
                    drv_val <= 1'b0;
                    unique case (phase)
                        PH_CTRL: begin
                            if (rd_sel) begin
                                phase   <= PH_RDAT;
                                tx      <= rd_data;
                                drv_val <= !rd_data[BYTE_W-1];
                            end else begin
                                phase <= PH_AHI;
                            end
                        end
                        PH_AHI: phase <= PH_ALO;
                        PH_ALO: phase <= PH_WDAT;
                        PH_RDAT: begin
                            if (m_ack) begin
                                tx      <= rd_data;
                                drv_val <= !rd_data[BYTE_W-1];
                            end else begin
                                phase <= PH_SKIP;
                            end
                        end
                        default: ;
                    endcase
                end else if ((phase == PH_RDAT) && (bitcnt != '0)) begin
                    drv_req <= 1'b1;
                    drv_val <= !tx[tx_idx];
                end
            end
        end
    end
endmodule

// File: rtl/i2cm_slave.sv
// Top of the two-wire memory slave: synchronizer, protocol engine,
// delayed open-drain output stage and the byte memory.
// Assumes the system clock runs many times faster than the bus clock.
module i2cm_slave
    import i2cm_pkg::*;
#(
    parameter int AW          = 12,
    parameter int SYNC_STAGES = 2,
    parameter int HOLD_CYC    = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               scl_i,
    input  logic               sda_i,
    output logic               sda_oe,
    input  logic [STRAP_W-1:0] strap_i,
    input  logic               busy_i
);
    logic              sda_lvl;
    logic              scl_rise;
    logic              scl_fall;
    logic              start_det;
    logic              stop_det;
    phase_t            phase;
    logic              byte_evt;
    logic              drv_req;
    logic              drv_val;
    logic              ram_we;
    logic [AW-1:0]     ram_waddr;
    logic [BYTE_W-1:0] ram_wdata;
    logic [AW-1:0]     ptr;
    logic [BYTE_W-1:0] rd_data;

    i2cm_line_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .sda_lvl   (sda_lvl),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    i2cm_proto #(.AW(AW)) u_proto (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det),
        .sda_lvl   (sda_lvl),
        .strap_i   (strap_i),
        .busy_i    (busy_i),
        .rd_data   (rd_data),
        .phase     (phase),
        .byte_evt  (byte_evt),
        .drv_req   (drv_req),
        .drv_val   (drv_val),
        .ram_we    (ram_we),
        .ram_waddr (ram_waddr),
        .ram_wdata (ram_wdata),
        .ptr       (ptr)
    );

    i2cm_sda_drv #(.HOLD_CYC(HOLD_CYC)) u_drv (
        .clk     (clk),
        .rst_n   (rst_n),
        .drv_req (drv_req),
        .drv_val (drv_val),
        .sda_oe  (sda_oe)
    );

    i2cm_ram #(.AW(AW), .DW(BYTE_W)) u_ram (
        .clk   (clk),
        .we    (ram_we),
        .waddr (ram_waddr),
        .wdata (ram_wdata),
        .raddr (ptr),
        .rdata (rd_data)
    );
endmodule

// File: rtl/i2cm_slave_chk.sv
// Property checker for the memory slave, bound to the top module.
// Observes state, condition pulses, drive requests and memory writes.
module i2cm_slave_chk
    import i2cm_pkg::*;
#(
    parameter int AW = 12
) (
    input logic          clk,
    input logic          rst_n,
    input phase_t        phase,
    input logic          start_det,
    input logic          stop_det,
    input logic          busy_i,
    input logic          byte_evt,
    input logic          drv_req,
    input logic          drv_val,
    input logic          ram_we,
    input logic [AW-1:0] ram_waddr,
    input logic [AW-1:0] ptr
);
    p_start_restart_r1: assert property (@(posedge clk) disable iff (!rst_n)
        start_det |=> (phase == PH_CTRL));

    p_stop_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_det && !start_det) |=> (phase == PH_IDLE));

    p_busy_no_ack_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_i && byte_evt && (phase != PH_RDAT)) |=> !(drv_req && drv_val));

    p_busy_no_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_i && byte_evt) |=> !ram_we);

    p_write_advance_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ram_we |-> (ptr == AW'(ram_waddr + 1'b1)));

    p_silent_no_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ((phase == PH_SKIP) && $past(phase == PH_SKIP)) |-> !ram_we);
endmodule

bind i2cm_slave i2cm_slave_chk #(.AW(AW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .phase     (phase),
    .start_det (start_det),
    .stop_det  (stop_det),
    .busy_i    (busy_i),
    .byte_evt  (byte_evt),
    .drv_req   (drv_req),
    .drv_val   (drv_val),
    .ram_we    (ram_we),
    .ram_waddr (ram_waddr),
    .ptr       (ptr)
);

// File: tb/i2cm_slave_tb_top.sv
// Bench: a behavioural bus master with a byte-array memory model and an
// integer pointer, plus a per-clock monitor on the data output.
module i2cm_slave_tb_top;
    localparam int         CLK_PERIOD = 10;
    localparam int         H          = 24;
    localparam logic [2:0] STRAP      = 3'b101;
    localparam logic [7:0] CW_BYTE    = {4'b1010, STRAP, 1'b0};
    localparam logic [7:0] CR_BYTE    = {4'b1010, STRAP, 1'b1};

    logic clk   = 1'b0;
    logic rst_n = 1'b0;
    logic scl_m = 1'b1;
    logic sda_m = 1'b1;
    logic busy  = 1'b0;
    logic sda_oe;
    logic sda_line;

    int   checks = 0;
    int   errors = 0;
    bit   done   = 1'b0;
    logic [7:0] mem_m [4096];
    int   ptr_m  = 0;
    logic oe_prev = 1'b0;

    assign sda_line = sda_m & ~sda_oe;

    always #(CLK_PERIOD/2) clk = ~clk;

    i2cm_slave dut_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .scl_i   (scl_m),
        .sda_i   (sda_line),
        .sda_oe  (sda_oe),
        .strap_i (STRAP),
        .busy_i  (busy)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // R11: per-clock monitor, output must hold while the bus clock is high
    always @(posedge clk) begin
        #(CLK_PERIOD/4);
        if (rst_n && !done) begin
            if (scl_m) chk("R11 output moved while clock high", sda_oe, oe_prev);
            oe_prev = sda_oe;
        end
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; tick(H/2);
        scl_m = 1'b1; tick(H/2);
        sda_m = 1'b0; tick(H/2);
        scl_m = 1'b0; tick(H/2);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; tick(H/2);
        scl_m = 1'b1; tick(H/2);
        sda_m = 1'b1; tick(H);
    endtask

    task automatic bit_cycle(input logic b, output logic s);
        sda_m = b;    tick(H/2);
        scl_m = 1'b1; tick(H/2);
        s = sda_line; tick(H/2);
        scl_m = 1'b0; tick(H/2);
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        logic s;
        for (int i = 7; i >= 0; i--) bit_cycle(b[i], s);
        bit_cycle(1'b1, s);
        ack = (s === 1'b0);
    endtask

    task automatic recv_byte(input logic mack, output logic [7:0] d);
        logic s;
        for (int i = 7; i >= 0; i--) begin
            bit_cycle(1'b1, s);
            d[i] = s;
        end
        bit_cycle(mack ? 1'b0 : 1'b1, s);
    endtask

    // Write with full address and data bytes (R2, R4, R6)
    task automatic write_seq(input logic [15:0] a16, input logic [7:0] data [$], input string tag);
        logic ack;
        bus_start();
        send_byte(CW_BYTE, ack);     chk("R2 write control ack", ack, 1'b1);
        send_byte(a16[15:8], ack);   chk("R4 high address ack", ack, 1'b1);
        send_byte(a16[7:0], ack);    chk("R4 low address ack", ack, 1'b1);
        ptr_m = int'(a16[11:0]);
        foreach (data[i]) begin
            send_byte(data[i], ack); chk({tag, " data byte ack"}, ack, 1'b1);
            mem_m[ptr_m] = data[i];
            ptr_m = (ptr_m + 1) % 4096;
        end
        bus_stop();
    endtask

    // Address-only write, repeated start, then n read bytes (R8, R9)
    task automatic rand_read(input logic [11:0] a, input int n, input string tag);
        logic ack;
        logic [7:0] d;
        bus_start();
        send_byte(CW_BYTE, ack);          chk("R8 preamble control ack", ack, 1'b1);
        send_byte({4'h0, a[11:8]}, ack);  chk("R8 preamble high ack", ack, 1'b1);
        send_byte(a[7:0], ack);           chk("R8 preamble low ack", ack, 1'b1);
        ptr_m = int'(a);
        bus_start();
        send_byte(CR_BYTE, ack);          chk("R8 read control ack", ack, 1'b1);
        for (int i = 0; i < n; i++) begin
            recv_byte(i < n - 1, d);
            chk({tag, " read data"}, d, mem_m[ptr_m]);
            ptr_m = (ptr_m + 1) % 4096;
        end
        chk("R9 released after master nack", sda_oe, 1'b0);
        bus_stop();
    endtask

    initial begin
        logic ack;
        logic [7:0] d;
        logic s;
        tick(5);
        rst_n = 1'b1;
        tick(2);
        chk("R1 reset output", sda_oe, 1'b0);
        tick(5);

        // R4/R6: top nibble of high address ignored, three bytes in a row
        write_seq({4'hF, 12'h123}, '{8'hA5, 8'h5A, 8'h96}, "R6");
        rand_read(12'h123, 1, "R8 R4");

        // R7: current-address read continues after the last byte read
        bus_start();
        send_byte(CR_BYTE, ack);  chk("R7 read control ack", ack, 1'b1);
        recv_byte(1'b0, d);       chk("R7 current address data", d, mem_m[ptr_m]);
        ptr_m = (ptr_m + 1) % 4096;
        bus_stop();
        chk("R1 released after stop", sda_oe, 1'b0);

        // R10: wrap on write and on sequential read
        write_seq(16'h0FFF, '{8'h3C, 8'hC3}, "R10");
        rand_read(12'hFFF, 2, "R10 R9");

        // R3: strap mismatch, following bytes silent and not stored
        bus_start();
        send_byte({4'b1010, STRAP ^ 3'b001, 1'b0}, ack); chk("R3 strap mismatch nack", ack, 1'b0);
        send_byte(8'h01, ack);    chk("R3 silent address", ack, 1'b0);
        send_byte(8'h23, ack);    chk("R3 silent address", ack, 1'b0);
        send_byte(8'h00, ack);    chk("R3 silent data", ack, 1'b0);
        bus_stop();
        rand_read(12'h123, 1, "R3 memory unchanged");

        // R3: prefix mismatch
        bus_start();
        send_byte({4'b1011, STRAP, 1'b0}, ack); chk("R3 prefix mismatch nack", ack, 1'b0);
        bus_stop();

        // R5: busy write engine blocks every acknowledge and the write
        busy = 1'b1;
        bus_start();
        send_byte(CW_BYTE, ack);  chk("R5 busy control nack", ack, 1'b0);
        send_byte(8'h01, ack);    chk("R5 busy address nack", ack, 1'b0);
        send_byte(8'h24, ack);    chk("R5 busy address nack", ack, 1'b0);
        send_byte(8'h77, ack);    chk("R5 busy data nack", ack, 1'b0);
        bus_stop();
        busy = 1'b0;
        tick(4);
        rand_read(12'h124, 1, "R5 memory unchanged");

        // R1: start in the middle of an address byte restarts the transfer
        bus_start();
        send_byte(CW_BYTE, ack);  chk("R1 control ack before abort", ack, 1'b1);
        for (int i = 0; i < 4; i++) bit_cycle(1'b0, s);
        bus_start();
        send_byte(CR_BYTE, ack);  chk("R1 read control ack after restart", ack, 1'b1);
        recv_byte(1'b0, d);       chk("R1 read after restart data", d, mem_m[ptr_m]);
        ptr_m = (ptr_m + 1) % 4096;
        bus_stop();
        chk("R1 released after final stop", sda_oe, 1'b0);

        done = 1'b1;
        tick(2);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule